// File: doc/BRIEF.md
# I2C Bus Condition Request Control

This block is the control-and-status register for an I2C controller that can act as master or slave. Software asks for a START, a repeated START or a STOP by writing request bits. The block passes each request to a separate condition generator as a single-cycle issue strobe. It then holds the request bit until the generator answers with a done pulse, until arbitration is lost, or until a reset clears it.

The same register holds the master/slave and transmit/receive mode bits. Software can change these bits only while a separate unlock input is high. A completed START sets both of them. A read-only bus-busy flag follows the line itself: a START or STOP seen on synchronised SDA and SCL samples sets or clears the flag. A START request waits while that flag shows the bus occupied.

Only one condition is in flight at a time. When several requests are pending, STOP goes first, then repeated START, then START. Hardware clears always win over a software write in the same cycle.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `rd_data` reads 0x00 and all three issue strobes are 0.
- R2: The read image is bit7 busy, bit6 master, bit5 transmit, bit3 STOP request, bit2 repeated-START request and bit1 START request. Bits 4 and 0 always read 0, whatever is written to them.
- R3: The busy flag (bit7) ignores writes. It goes to 1 on SDA falling while SCL is high and returns to 0 on SDA rising while SCL is high. It changes on the third clock edge after the line change.
- R4: A write with `wr_en` loads request bits 3..1 from `wr_data`: 1 sets a bit and 0 clears it.
- R5: A pending request produces its issue strobe for exactly one cycle. The strobe starts on the edge after the request bit reads 1, and it does not repeat before the request is cleared.
- R6: A START request produces no strobe while the busy flag is 1. Its strobe follows one edge after the flag reads 0.
- R7: A done pulse clears its own request bit. `start_done` also sets the master and transmit bits.
- R8: `arb_lost` clears all three request bits and suppresses any strobe on the following edge.
- R9: `soft_rst` clears the request bits and the mode bits.
- R10: The master and transmit bits take written values only when `mode_unlock` is 1. Otherwise they keep their value.
- R11: A hardware clear (`*_done`, `arb_lost`, `soft_rst`) in the same cycle as a software write wins over the write.
- R12: At most one strobe is active at a time. No new strobe issues while a condition is outstanding. Among pending requests, STOP is served before repeated START, and repeated START before START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| soft_rst | input | 1 | Controller/internal reset: clears requests and mode bits |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| mode_unlock | input | 1 | Enables writes to the master and transmit bits |
| rd_data | output | 8 | Register read image |
| sda_in | input | 1 | Raw SDA line sample |
| scl_in | input | 1 | Raw SCL line sample |
| arb_lost | input | 1 | Arbitration-lost event pulse |
| start_done | input | 1 | Generator finished a START |
| restart_done | input | 1 | Generator finished a repeated START |
| stop_done | input | 1 | Generator finished a STOP |
| start_issue | output | 1 | One-cycle START strobe |
| restart_issue | output | 1 | One-cycle repeated-START strobe |
| stop_issue | output | 1 | One-cycle STOP strobe |

## Verification
A software write to the request bits can fall in the same cycle as a hardware clear, either a generator done pulse or an arbitration loss. The bench provokes this by driving `wr_en`, with a value that sets the request, together with `start_done` or `arb_lost` in one cycle. It judges the result by reading the register on the next cycle and expecting the request bit to be 0. A second collision is a pending START when the busy flag drops. Here the bench checks that the strobe appears exactly one edge after the flag reads 0, and not before.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int REG_W       = 8;
    localparam int NUM_COND    = 3;
    localparam int BUSY_BIT    = 7;
    localparam int MST_BIT     = 6;
    localparam int TRS_BIT     = 5;
    localparam int STOP_BIT    = 3;
    localparam int RESTART_BIT = 2;
    localparam int START_BIT   = 1;

    typedef enum logic [1:0] {
        COND_START   = 2'd0,
        COND_RESTART = 2'd1,
        COND_STOP    = 2'd2
    } cond_e;

    typedef struct packed {
        logic busy;
        logic mst;
        logic trs;
        logic sp;
        logic rs;
        logic st;
    } reg_image_t;

    function automatic logic [REG_W-1:0] pack_image(input reg_image_t img);
        logic [REG_W-1:0] r;
        r              = '0;
        r[BUSY_BIT]    = img.busy;
        r[MST_BIT]     = img.mst;
        r[TRS_BIT]     = img.trs;
        r[STOP_BIT]    = img.sp;
        r[RESTART_BIT] = img.rs;
        r[START_BIT]   = img.st;
        return r;
    endfunction

    function automatic int req_bit_pos(input int idx);
        case (idx)
            0:       return START_BIT;
            1:       return RESTART_BIT;
            default: return STOP_BIT;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sda_in,
    input  logic scl_in,
    output logic busy_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sda_sync;
    logic [LAST:0] scl_sync;
    logic          sda_prev;
    logic          start_seen;
    logic          stop_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_sync <= '1;
            scl_sync <= '1;
            sda_prev <= 1'b1;
        end else begin
            sda_sync <= {sda_sync[LAST-1:0], sda_in};
            scl_sync <= {scl_sync[LAST-1:0], scl_in};
            sda_prev <= sda_sync[LAST];
        end
    end

    always_comb begin
        start_seen = scl_sync[LAST] &  sda_prev & ~sda_sync[LAST];
        stop_seen  = scl_sync[LAST] & ~sda_prev &  sda_sync[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst)             busy_o <= 1'b0;
        else if (start_seen) busy_o <= 1'b1;
        else if (stop_seen)  busy_o <= 1'b0;
    end

endmodule

// File: rtl/i2c_req_slot.sv
module i2c_req_slot (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic arb_lost,
    input  logic done,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic grant,
    output logic req_o,
    output logic pending_o,
    output logic outstanding_o,
    output logic issue_o
);
    logic hw_clr;
    logic req_d;
    logic out_d;

    always_comb begin
        hw_clr = soft_rst | arb_lost | done;
        if (hw_clr)     req_d = 1'b0;
        else if (wr_en) req_d = wr_bit;
        else            req_d = req_o;
        pending_o = req_o & req_d;
        out_d     = (outstanding_o | grant) & req_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o         <= 1'b0;
            outstanding_o <= 1'b0;
            issue_o       <= 1'b0;
        end else begin
            req_o         <= req_d;
            outstanding_o <= out_d;
            issue_o       <= grant;
        end
    end

endmodule

// File: rtl/i2c_cond_grant.sv
module i2c_cond_grant
    import i2c_cond_pkg::*;
(
    input  logic [NUM_COND-1:0] pending,
    input  logic [NUM_COND-1:0] outstanding,
    input  logic                bus_busy,
    output logic [NUM_COND-1:0] grant
);
    logic [NUM_COND-1:0] ready;
    logic                any_out;

    always_comb begin
        any_out = |outstanding;
        ready   = pending & {NUM_COND{~any_out}};
        ready[COND_START] = ready[COND_START] & ~bus_busy;
        grant   = '0;
        for (int i = NUM_COND - 1; i >= 0; i--) begin
            if (ready[i] && (grant == '0)) grant[i] = 1'b1;
        end
    end

endmodule

// File: rtl/i2c_mode_regs.sv
module i2c_mode_regs
    import i2c_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic             mode_unlock,
    input  logic [REG_W-1:0] wr_data,
    input  logic             start_done,
    output logic             mst_o,
    output logic             trs_o
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            mst_o <= 1'b0;
            trs_o <= 1'b0;
        end else if (start_done) begin
            mst_o <= 1'b1;
            trs_o <= 1'b1;
        end else if (wr_en && mode_unlock) begin
            mst_o <= wr_data[MST_BIT];
            trs_o <= wr_data[TRS_BIT];
        end
    end

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             mode_unlock,
    output logic [REG_W-1:0] rd_data,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             arb_lost,
    input  logic             start_done,
    input  logic             restart_done,
    input  logic             stop_done,
    output logic             start_issue,
    output logic             restart_issue,
    output logic             stop_issue
);
    logic                busy;
    logic                mst;
    logic                trs;
    logic [NUM_COND-1:0] done_vec;
    logic [NUM_COND-1:0] req_vec;
    logic [NUM_COND-1:0] pend_vec;
    logic [NUM_COND-1:0] out_vec;
    logic [NUM_COND-1:0] issue_vec;
    logic [NUM_COND-1:0] grant_vec;
    reg_image_t          img;

    i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
        .clk    (clk),
        .rst    (rst),
        .sda_in (sda_in),
        .scl_in (scl_in),
        .busy_o (busy)
    );

    always_comb begin
        done_vec[COND_START]   = start_done;
        done_vec[COND_RESTART] = restart_done;
        done_vec[COND_STOP]    = stop_done;
    end

    for (genvar g = 0; g < NUM_COND; g++) begin : g_slot
        i2c_req_slot slot_i (
            .clk           (clk),
            .rst           (rst),
            .soft_rst      (soft_rst),
            .arb_lost      (arb_lost),
            .done          (done_vec[g]),
            .wr_en         (wr_en),
            .wr_bit        (wr_data[req_bit_pos(g)]),
            .grant         (grant_vec[g]),
            .req_o         (req_vec[g]),
            .pending_o     (pend_vec[g]),
            .outstanding_o (out_vec[g]),
            .issue_o       (issue_vec[g])
        );
    end

    i2c_cond_grant grant_i (
        .pending     (pend_vec),
        .outstanding (out_vec),
        .bus_busy    (busy),
        .grant       (grant_vec)
    );

    i2c_mode_regs mode_i (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst),
        .wr_en       (wr_en),
        .mode_unlock (mode_unlock),
        .wr_data     (wr_data),
        .start_done  (start_done),
        .mst_o       (mst),
        .trs_o       (trs)
    );

    always_comb begin
        img.busy      = busy;
        img.mst       = mst;
        img.trs       = trs;
        img.sp        = req_vec[COND_STOP];
        img.rs        = req_vec[COND_RESTART];
        img.st        = req_vec[COND_START];
        rd_data       = pack_image(img);
        start_issue   = issue_vec[COND_START];
        restart_issue = issue_vec[COND_RESTART];
        stop_issue    = issue_vec[COND_STOP];
    end

endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
module i2c_cond_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       wr_en,
    input logic       mode_unlock,
    input logic [7:0] rd_data,
    input logic       arb_lost,
    input logic       start_done,
    input logic       start_issue,
    input logic       restart_issue,
    input logic       stop_issue
);
    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_issue, restart_issue, stop_issue}));

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_issue |=> !start_issue);

    // R5
    stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stop_issue |=> !stop_issue);

    // R6
    start_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
        start_issue |-> !$past(rd_data[7]));

    // R8
    arb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost |=> (rd_data[3:1] == 3'b000) && !start_issue && !restart_issue && !stop_issue);

    // R7
    start_done_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (start_done && !soft_rst) |=> (rd_data[6] && rd_data[5] && !rd_data[1]));

    // R9
    soft_rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (rd_data[6:1] == 6'b0));

    // R10
    mode_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && mode_unlock) && !start_done && !soft_rst) |=> $stable(rd_data[6:5]));

endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .soft_rst      (soft_rst),
    .wr_en         (wr_en),
    .mode_unlock   (mode_unlock),
    .rd_data       (rd_data),
    .arb_lost      (arb_lost),
    .start_done    (start_done),
    .start_issue   (start_issue),
    .restart_issue (restart_issue),
    .stop_issue    (stop_issue)
);

// File: tb/i2c_cond_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mode_unlock = 1'b0;
    logic [7:0] rd_data;
    logic       sda_in = 1'b1;
    logic       scl_in = 1'b1;
    logic       arb_lost = 1'b0;
    logic       start_done = 1'b0;
    logic       restart_done = 1'b0;
    logic       stop_done = 1'b0;
    logic       start_issue;
    logic       restart_issue;
    logic       stop_issue;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    i2c_cond_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .soft_rst      (soft_rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .mode_unlock   (mode_unlock),
        .rd_data       (rd_data),
        .sda_in        (sda_in),
        .scl_in        (scl_in),
        .arb_lost      (arb_lost),
        .start_done    (start_done),
        .restart_done  (restart_done),
        .stop_done     (stop_done),
        .start_issue   (start_issue),
        .restart_issue (restart_issue),
        .stop_issue    (stop_issue)
    );

    // {wr_data, mode_unlock, expected rd_data}, R2 R4 R10 R3
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {8'hFF, 1'b0, 8'h0E},
        {8'h00, 1'b0, 8'h00},
        {8'h60, 1'b1, 8'h60},
        {8'h9F, 1'b0, 8'h6E},
        {8'h00, 1'b1, 8'h00},
        {8'h22, 1'b1, 8'h22},
        {8'h04, 1'b0, 8'h24},
        {8'h08, 1'b0, 8'h28}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobes(input string tag, input logic [2:0] exp);
        check(tag, {5'b0, stop_issue, restart_issue, start_issue}, {5'b0, exp});
    endtask

    task automatic write(input logic [7:0] d, input logic unlock);
        wr_en = 1'b1; wr_data = d; mode_unlock = unlock;
        tick();
        wr_en = 1'b0; mode_unlock = 1'b0;
    endtask

    task automatic pulse_soft();
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 reset rd_data", rd_data, 8'h00);
        strobes("R1 reset strobes", 3'b000);

        // vector walk: R2 R4 R10 R3 (busy ignores writes)
        for (int i = 0; i < NVEC; i++) begin
            write(VEC[i][16:9], VEC[i][8]);
            check($sformatf("R2/R4/R10 vector %0d", i), rd_data, VEC[i][7:0]);
        end
        pulse_soft();
        // R9
        check("R9 soft reset clears", rd_data, 8'h00);

        // R5 strobe timing, R7 done handling
        write(8'h02, 1'b0);
        check("R4 start set", rd_data, 8'h02);
        strobes("R5 no strobe yet", 3'b000);
        tick();
        strobes("R5 start strobe", 3'b001);
        tick();
        strobes("R5 strobe one cycle", 3'b000);
        tick(); tick();
        strobes("R5 no repeat", 3'b000);
        start_done = 1'b1; tick(); start_done = 1'b0;
        check("R7 start done", rd_data, 8'h60);
        pulse_soft();

        // R3 busy detection timing
        sda_in = 1'b0;
        tick(); tick();
        check("R3 busy not yet", rd_data, 8'h00);
        tick();
        check("R3 busy set", rd_data, 8'h80);

        // R6 start held while busy
        write(8'h02, 1'b0);
        for (int k = 0; k < 5; k++) tick();
        strobes("R6 held while busy", 3'b000);
        sda_in = 1'b1;
        tick(); tick(); tick();
        check("R3 busy cleared", rd_data, 8'h02);
        strobes("R6 not yet", 3'b000);
        tick();
        strobes("R6 start after free", 3'b001);

        // R8 arbitration lost
        write(8'h0E, 1'b0);
        arb_lost = 1'b1; tick(); arb_lost = 1'b0;
        check("R8 arb lost clears", rd_data, 8'h00);
        strobes("R8 no strobe", 3'b000);

        // R11 hardware clear beats write
        write(8'h02, 1'b0);
        tick();
        wr_en = 1'b1; wr_data = 8'h02; start_done = 1'b1;
        tick();
        wr_en = 1'b0; start_done = 1'b0;
        check("R11 done beats write", rd_data, 8'h60);
        wr_en = 1'b1; wr_data = 8'h0E; arb_lost = 1'b1;
        tick();
        wr_en = 1'b0; arb_lost = 1'b0;
        check("R11 arb beats write", rd_data, 8'h60);
        wr_en = 1'b1; wr_data = 8'h6E; mode_unlock = 1'b1; soft_rst = 1'b1;
        tick();
        wr_en = 1'b0; mode_unlock = 1'b0; soft_rst = 1'b0;
        check("R11 soft reset beats write", rd_data, 8'h00);

        // R12 ordering
        write(8'h0E, 1'b0);
        tick();
        strobes("R12 stop first", 3'b100);
        tick();
        strobes("R12 one outstanding", 3'b000);
        stop_done = 1'b1; tick(); stop_done = 1'b0;
        check("R7 stop done clears", rd_data, 8'h06);
        strobes("R12 gap after done", 3'b000);
        tick();
        strobes("R12 restart second", 3'b010);
        tick();
        restart_done = 1'b1; tick(); restart_done = 1'b0;
        check("R7 restart done clears", rd_data, 8'h02);
        tick();
        strobes("R12 start last", 3'b001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule